// File: doc/BRIEF.md
# Completion Timeout Tracker

This block watches requests that leave a requester and expect an answer, and it reports any request whose answer does not arrive in time. Each accepted request carries a type code and a 3-bit tag. The block classifies the type. A request that expects a completion occupies the tracking slot named by its tag, and that slot starts its own age counter. A returning completion with the same tag and an acceptable kind frees the slot. If the counter reaches the programmed limit first, the block frees the slot and sends out a one-cycle timeout event that carries the tag.

Software chooses one of four limits and can switch timeout reporting off at any time, including while requests are outstanding. While reporting is off the counters keep running, but expiries are held back. A slot that is overdue when reporting is switched back on times out at the next edge. Two read-only outputs describe what software may use: which limits exist, and that the off switch exists. Completions that match no busy slot, or whose kind does not fit the slot, are reported as unexpected and change nothing else.

The request side is a valid/ready stream, and a request transfers on a cycle where both are high. `req_ready` depends only on the type and tag presented with the request and never waits for `req_valid`. It is low only when the request expects a completion and its tag's slot is busy. Posted requests are never stalled. The completion side is a strobe with no back-pressure: every `cpl_valid` cycle is consumed.

Top module: `cpl_tmo_tracker`

## Requirements
- R1: The request types that expect a completion allocate the slot named by `req_tag` when accepted. They are read class: memory read (0), locked memory read (1), I/O read (2), config type 0 read (4), config type 1 read (6). They are write class: I/O write (3), config type 0 write (5), config type 1 write (7).
- R2: Memory write (8), message (9), message with data (10) and the reserved codes 11 to 15 are posted. They never allocate a slot and always see `req_ready` high.
- R3: `req_ready` is low when `req_valid` presents a non-posted type whose tag slot is busy; a posted type with the same tag sees it high.
- R4: A read-class slot is freed by a completion with `cpl_has_data`=1, or by one with `cpl_has_data`=0 and `cpl_err`=1. A completion with no data and no error is unexpected and leaves the slot busy.
- R5: A write-class slot is freed only by a completion with `cpl_has_data`=0, whatever `cpl_err` is. A completion with data is unexpected and leaves the slot busy.
- R6: Let the request be accepted at edge E. If no completion frees the slot, `tmo_valid` is high with `tmo_tag` equal to the tag for exactly the one cycle after edge E+2^(TBASE+2*`tmo_sel`), and the slot is freed.
- R7: A completion that frees no slot raises `unexp_valid` with `unexp_tag` for the one cycle after the edge that sampled it.
- R8: While `tmo_disable`=1 no timeout event appears and completions still free slots. After the bit clears, a slot already past its limit times out at the next edge.
- R9: If a slot's freeing completion is sampled at the same edge at which the slot would expire, the completion wins: no timeout event and no unexpected event.
- R10: When several slots are due at once, one event is issued per cycle, lowest tag first.
- R11: `tmo_count` increments by one for each timeout event and holds at its all-ones maximum.
- R12: `cap_range_mask` reads 4'b1111 (all four limits supported) and `cap_dis_support` reads 1.
- R13: After reset every slot is idle, timeout reporting is enabled by default, there are no events, and `tmo_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_type | input | 4 | Request type code (see R1, R2) |
| req_tag | input | TAGW (3) | Request tag, equals slot index |
| cpl_valid | input | 1 | Completion observed this cycle |
| cpl_tag | input | TAGW (3) | Completion tag |
| cpl_has_data | input | 1 | Completion carries data |
| cpl_err | input | 1 | Completion status is not success |
| tmo_sel | input | 2 | Limit select: 2^(TBASE+2*sel) cycles |
| tmo_disable | input | 1 | 1 masks all timeout events |
| cap_range_mask | output | 4 | Supported limit selects, read-only |
| cap_dis_support | output | 1 | Disable switch supported, read-only |
| tmo_valid | output | 1 | One-cycle timeout event |
| tmo_tag | output | TAGW (3) | Tag of the timed-out request |
| tmo_count | output | CNTW (8) | Saturating timeout count |
| unexp_valid | output | 1 | One-cycle unexpected completion event |
| unexp_tag | output | TAGW (3) | Tag of the unexpected completion |

## Verification
A slot can expire in the same cycle as it is freed by its own completion, so the two closing paths of a slot meet on one edge. The bench counts edges from the acceptance edge and places the completion so that it is sampled exactly at the edge on which the age counter reaches its limit. It passes if neither a timeout nor an unexpected event follows and a second completion for that tag is then reported as unexpected, which shows the slot was freed exactly once.

// File: rtl/cpl_tmo_pkg.sv
package cpl_tmo_pkg;

  // Request type codes seen on req_type
  typedef enum logic [3:0] {
    RQ_MEM_RD    = 4'd0,
    RQ_MEM_RD_LK = 4'd1,
    RQ_IO_RD     = 4'd2,
    RQ_IO_WR     = 4'd3,
    RQ_CFG0_RD   = 4'd4,
    RQ_CFG0_WR   = 4'd5,
    RQ_CFG1_RD   = 4'd6,
    RQ_CFG1_WR   = 4'd7,
    RQ_MEM_WR    = 4'd8,
    RQ_MSG       = 4'd9,
    RQ_MSG_DATA  = 4'd10
  } req_kind_e;

  // How a request is closed
  typedef enum logic [1:0] {
    CLS_POSTED = 2'd0,
    CLS_RD     = 2'd1,
    CLS_WR     = 2'd2
  } cpl_class_e;

  localparam int NUM_LIMITS = 4;

endpackage

// File: rtl/cpl_tmo_classify.sv
module cpl_tmo_classify
  import cpl_tmo_pkg::*;
(
  input  logic [3:0]  kind,
  output cpl_class_e  cls
);

  always_comb begin
    case (kind)
      RQ_MEM_RD, RQ_MEM_RD_LK, RQ_IO_RD, RQ_CFG0_RD, RQ_CFG1_RD: cls = CLS_RD;
      RQ_IO_WR, RQ_CFG0_WR, RQ_CFG1_WR:                          cls = CLS_WR;
      default:                                                   cls = CLS_POSTED;
    endcase
  end

endmodule

// File: rtl/cpl_tmo_slot.sv
module cpl_tmo_slot
  import cpl_tmo_pkg::*;
#(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  cpl_class_e    alloc_cls,
  input  logic          cpl_sel,
  input  logic          cpl_data,
  input  logic          cpl_err,
  input  logic [CW-1:0] limit_m1,
  input  logic          tmo_dis,
  input  logic          grant,
  output logic          busy,
  output logic          close,
  output logic          expire_req
);

  logic          is_wr;
  logic [CW-1:0] age;
  logic          overdue;

  // Write-class closes on a no-data completion; read-class on data or error
  assign close      = cpl_sel && busy && (is_wr ? !cpl_data : (cpl_data || cpl_err));
  assign overdue    = busy && (age >= limit_m1);
  // A completion on the same edge wins over expiry
  assign expire_req = overdue && !tmo_dis && !close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_wr <= 1'b0;
      age   <= '0;
    end else if (alloc) begin
      busy  <= 1'b1;
      is_wr <= (alloc_cls == CLS_WR);
      age   <= '0;
    end else if (close || grant) begin
      busy  <= 1'b0;
    end else if (busy && (age != '1)) begin
      age   <= age + 1'b1;
    end
  end

endmodule

// File: rtl/cpl_tmo_arb.sv
module cpl_tmo_arb #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest index wins; scan downward so the last hit is the lowest
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/cpl_tmo_tracker.sv
module cpl_tmo_tracker
  import cpl_tmo_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int TBASE = 10,
  parameter int CNTW  = 8,
  parameter int TAGW  = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_type,
  input  logic [TAGW-1:0] req_tag,
  input  logic            cpl_valid,
  input  logic [TAGW-1:0] cpl_tag,
  input  logic            cpl_has_data,
  input  logic            cpl_err,
  input  logic [1:0]      tmo_sel,
  input  logic            tmo_disable,
  output logic [3:0]      cap_range_mask,
  output logic            cap_dis_support,
  output logic            tmo_valid,
  output logic [TAGW-1:0] tmo_tag,
  output logic [CNTW-1:0] tmo_count,
  output logic            unexp_valid,
  output logic [TAGW-1:0] unexp_tag
);

  // Age counter wide enough for the largest limit plus one for saturation
  localparam int CW = TBASE + 2 * (NUM_LIMITS - 1) + 1;

  cpl_class_e       req_cls;
  logic             needs_cpl;
  logic             req_fire;
  logic [CW-1:0]    limit_m1;
  logic [NSLOT-1:0] alloc_vec;
  logic [NSLOT-1:0] cpl_sel_vec;
  logic [NSLOT-1:0] busy_vec;
  logic [NSLOT-1:0] close_vec;
  logic [NSLOT-1:0] exp_vec;
  logic [NSLOT-1:0] gnt_vec;
  logic             exp_any;
  logic [TAGW-1:0]  exp_idx;

  cpl_tmo_classify cls_i (
    .kind (req_type),
    .cls  (req_cls)
  );

  assign needs_cpl = (req_cls != CLS_POSTED);
  assign req_ready = !(needs_cpl && busy_vec[req_tag]);
  assign req_fire  = req_valid && req_ready;

  assign limit_m1 = (CW'(1) << (TBASE + 2 * int'(tmo_sel))) - CW'(1);

  assign cap_range_mask  = 4'b1111;
  assign cap_dis_support = 1'b1;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign alloc_vec[s]   = req_fire && needs_cpl && (req_tag == TAGW'(s));
    assign cpl_sel_vec[s] = cpl_valid && (cpl_tag == TAGW'(s));

    cpl_tmo_slot #(.CW(CW)) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (alloc_vec[s]),
      .alloc_cls  (req_cls),
      .cpl_sel    (cpl_sel_vec[s]),
      .cpl_data   (cpl_has_data),
      .cpl_err    (cpl_err),
      .limit_m1   (limit_m1),
      .tmo_dis    (tmo_disable),
      .grant      (gnt_vec[s]),
      .busy       (busy_vec[s]),
      .close      (close_vec[s]),
      .expire_req (exp_vec[s])
    );
  end

  cpl_tmo_arb #(.N(NSLOT), .IW(TAGW)) arb_i (
    .req (exp_vec),
    .gnt (gnt_vec),
    .any (exp_any),
    .idx (exp_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_valid   <= 1'b0;
      tmo_tag     <= '0;
      tmo_count   <= '0;
      unexp_valid <= 1'b0;
      unexp_tag   <= '0;
    end else begin
      tmo_valid   <= exp_any;
      unexp_valid <= cpl_valid && !(|close_vec);
      if (exp_any) begin
        tmo_tag <= exp_idx;
        if (tmo_count != '1) tmo_count <= tmo_count + 1'b1;
      end
      if (cpl_valid) unexp_tag <= cpl_tag;
    end
  end

endmodule

// File: rtl/cpl_tmo_tracker_chk.sv
module cpl_tmo_tracker_chk #(
  parameter int TAGW = 3,
  parameter int CNTW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [3:0]      req_type,
  input logic            cpl_valid,
  input logic            tmo_disable,
  input logic            tmo_valid,
  input logic [TAGW-1:0] tmo_tag,
  input logic [CNTW-1:0] tmo_count,
  input logic            unexp_valid
);

  // R8
  dis_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_valid |-> !$past(tmo_disable));

  // R6
  tmo_tag_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_valid |=> !(tmo_valid && (tmo_tag == $past(tmo_tag))));

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_valid && ($past(tmo_count) != '1)) |-> (tmo_count == CNTW'($past(tmo_count) + 1'b1)));

  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_valid |-> $stable(tmo_count));

  // R2
  posted_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_type >= 4'd8)) |-> req_ready);

  // R7
  unexp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unexp_valid |-> $past(cpl_valid));

endmodule

bind cpl_tmo_tracker cpl_tmo_tracker_chk #(.TAGW(TAGW), .CNTW(CNTW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_type    (req_type),
  .cpl_valid   (cpl_valid),
  .tmo_disable (tmo_disable),
  .tmo_valid   (tmo_valid),
  .tmo_tag     (tmo_tag),
  .tmo_count   (tmo_count),
  .unexp_valid (unexp_valid)
);

// File: tb/cpl_tmo_tracker_tb_top.sv
`timescale 1ns/1ps
module cpl_tmo_tracker_tb_top;

  localparam int TBASE = 4;
  localparam int CNTW  = 3;
  localparam int TAGW  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [3:0]      req_type = 4'd0;
  logic [TAGW-1:0] req_tag = '0;
  logic            cpl_valid = 1'b0;
  logic [TAGW-1:0] cpl_tag = '0;
  logic            cpl_has_data = 1'b0;
  logic            cpl_err = 1'b0;
  logic [1:0]      tmo_sel = 2'd0;
  logic            tmo_disable = 1'b0;
  logic [3:0]      cap_range_mask;
  logic            cap_dis_support;
  logic            tmo_valid;
  logic [TAGW-1:0] tmo_tag;
  logic [CNTW-1:0] tmo_count;
  logic            unexp_valid;
  logic [TAGW-1:0] unexp_tag;

  int n_run  = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpl_tmo_tracker #(.NSLOT(8), .TBASE(TBASE), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_has_data(cpl_has_data), .cpl_err(cpl_err),
    .tmo_sel(tmo_sel), .tmo_disable(tmo_disable),
    .cap_range_mask(cap_range_mask), .cap_dis_support(cap_dis_support),
    .tmo_valid(tmo_valid), .tmo_tag(tmo_tag), .tmo_count(tmo_count),
    .unexp_valid(unexp_valid), .unexp_tag(unexp_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a negedge
  task automatic issue(input logic [3:0] t, input logic [TAGW-1:0] g);
    req_valid = 1'b1; req_type = t; req_tag = g;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_cpl(input logic [TAGW-1:0] g, input logic d, input logic e);
    cpl_valid = 1'b1; cpl_tag = g; cpl_has_data = d; cpl_err = e;
    @(posedge clk);
    @(negedge clk);
    cpl_valid = 1'b0; cpl_has_data = 1'b0; cpl_err = 1'b0;
  endtask

  task automatic note_tmo();
    if (exp_cnt < (1 << CNTW) - 1) exp_cnt++;
  endtask

  // Expects event exactly limit edges after the acceptance edge
  task automatic wait_tmo(input string req, input logic [TAGW-1:0] g, input int limit);
    int early = 0;
    for (int k = 1; k < limit; k++) begin
      @(negedge clk);
      if (tmo_valid) early++;
    end
    check({req, " no early timeout"}, early, 0);
    @(negedge clk);
    check({req, " timeout pulse"}, tmo_valid, 1);
    check({req, " timeout tag"}, tmo_tag, g);
    note_tmo();
    check("R11 count", tmo_count, exp_cnt);
    @(negedge clk);
    check({req, " single cycle"}, tmo_valid, 0);
  endtask

  task automatic t_reset();
    check("R13 ready", req_ready, 1);
    check("R13 tmo_valid", tmo_valid, 0);
    check("R13 unexp_valid", unexp_valid, 0);
    check("R13 tmo_count", tmo_count, 0);
    check("R12 range mask", cap_range_mask, 4'b1111);
    check("R12 disable cap", cap_dis_support, 1);
  endtask

  task automatic t_read_close();
    issue(4'd0, 3'd1);
    send_cpl(3'd1, 1'b1, 1'b0);
    check("R1 R4 read closed by data", unexp_valid, 0);
    send_cpl(3'd1, 1'b1, 1'b0);
    check("R7 late completion unexpected", unexp_valid, 1);
    check("R7 unexpected tag", unexp_tag, 1);
    issue(4'd1, 3'd0);
    send_cpl(3'd0, 1'b1, 1'b0);
    check("R1 locked read closed", unexp_valid, 0);
  endtask

  task automatic t_read_err();
    issue(4'd4, 3'd2);
    send_cpl(3'd2, 1'b0, 1'b0);
    check("R4 no-data success on read unexpected", unexp_valid, 1);
    send_cpl(3'd2, 1'b0, 1'b1);
    check("R4 error completion closes read", unexp_valid, 0);
    send_cpl(3'd2, 1'b0, 1'b1);
    check("R4 slot freed", unexp_valid, 1);
  endtask

  task automatic t_write();
    issue(4'd3, 3'd3);
    send_cpl(3'd3, 1'b1, 1'b0);
    check("R5 data completion on write unexpected", unexp_valid, 1);
    send_cpl(3'd3, 1'b0, 1'b1);
    check("R5 no-data completion closes write", unexp_valid, 0);
    issue(4'd7, 3'd6);
    send_cpl(3'd6, 1'b0, 1'b0);
    check("R1 R5 cfg1 write closes", unexp_valid, 0);
  endtask

  task automatic t_posted();
    req_valid = 1'b1; req_type = 4'd8; req_tag = 3'd4;
    #1 check("R2 posted ready", req_ready, 1);
    issue(4'd8, 3'd4);
    issue(4'd9, 3'd4);
    issue(4'd10, 3'd4);
    issue(4'd15, 3'd4);
    send_cpl(3'd4, 1'b0, 1'b0);
    check("R2 posted allocates nothing (no data)", unexp_valid, 1);
    send_cpl(3'd4, 1'b1, 1'b0);
    check("R2 posted allocates nothing (data)", unexp_valid, 1);
  endtask

  task automatic t_stall();
    issue(4'd2, 3'd5);
    req_valid = 1'b1; req_type = 4'd6; req_tag = 3'd5;
    #1 check("R3 busy tag stalls", req_ready, 0);
    req_type = 4'd9;
    #1 check("R3 posted same tag not stalled", req_ready, 1);
    req_valid = 1'b0;
    @(negedge clk);
    send_cpl(3'd5, 1'b1, 1'b0);
    check("R3 stalled request did not replace slot", unexp_valid, 0);
  endtask

  task automatic t_timeout();
    tmo_sel = 2'd0;
    issue(4'd0, 3'd6);
    wait_tmo("R6 sel0", 3'd6, 1 << TBASE);
    send_cpl(3'd6, 1'b1, 1'b0);
    check("R6 slot freed after timeout", unexp_valid, 1);
    tmo_sel = 2'd1;
    issue(4'd5, 3'd2);
    wait_tmo("R6 sel1", 3'd2, 1 << (TBASE + 2));
    tmo_sel = 2'd0;
  endtask

  task automatic t_race();
    int stray = 0;
    issue(4'd0, 3'd2);
    repeat ((1 << TBASE) - 1) @(negedge clk);
    send_cpl(3'd2, 1'b1, 1'b0);
    check("R9 completion wins: no timeout", tmo_valid, 0);
    check("R9 completion wins: not unexpected", unexp_valid, 0);
    repeat (4) begin
      @(negedge clk);
      if (tmo_valid) stray++;
    end
    check("R9 no later timeout", stray, 0);
    send_cpl(3'd2, 1'b1, 1'b0);
    check("R9 slot freed once", unexp_valid, 1);
  endtask

  task automatic t_disable();
    int seen = 0;
    tmo_disable = 1'b1;
    issue(4'd0, 3'd0);
    repeat (40) begin
      @(negedge clk);
      if (tmo_valid) seen++;
    end
    check("R8 masked while disabled", seen, 0);
    send_cpl(3'd0, 1'b1, 1'b0);
    check("R8 completion frees while disabled", unexp_valid, 0);
    send_cpl(3'd0, 1'b1, 1'b0);
    check("R8 slot was freed", unexp_valid, 1);
    issue(4'd6, 3'd7);
    repeat (20) @(negedge clk);
    tmo_disable = 1'b0;
    @(negedge clk);
    check("R8 overdue fires on re-enable", tmo_valid, 1);
    check("R8 overdue tag", tmo_tag, 7);
    note_tmo();
    check("R11 count", tmo_count, exp_cnt);
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (tmo_valid) seen++;
    end
    check("R8 freed slot does not fire", seen, 0);
  endtask

  task automatic t_multi();
    tmo_disable = 1'b1;
    issue(4'd0, 3'd3);
    issue(4'd3, 3'd1);
    repeat (30) @(negedge clk);
    tmo_disable = 1'b0;
    @(negedge clk);
    check("R10 first event", tmo_valid, 1);
    check("R10 lowest tag first", tmo_tag, 1);
    note_tmo();
    @(negedge clk);
    check("R10 second event", tmo_valid, 1);
    check("R10 next tag", tmo_tag, 3);
    note_tmo();
    check("R11 count", tmo_count, exp_cnt);
    @(negedge clk);
    check("R10 no third event", tmo_valid, 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 3; i++) begin
      issue(4'd2, 3'd4);
      wait_tmo("R11 sat", 3'd4, 1 << TBASE);
    end
    check("R11 saturated", tmo_count, (1 << CNTW) - 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_close();
    t_read_err();
    t_write();
    t_posted();
    t_stall();
    t_timeout();
    t_race();
    t_disable();
    t_multi();
    t_saturate();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule